// File: doc/BRIEF.md
# Processor Status Flag Register with Bit Transfer

This block holds the eight condition and control flags of a small processor core in one byte. Each cycle it can take a masked flag update from the ALU. It can also perform one explicit operation selected by an operation code:
- set any flag, chosen by a 3-bit index;
- clear any flag, chosen by a 3-bit index;
- copy one chosen bit of a source byte into the transfer flag T;
- produce a copy of a source byte with one chosen bit replaced by T.

Every operation takes effect at the next clock edge. The bit-replace result is combinational, so a register-file write-back can take it in the same cycle. Bit 7, the global interrupt enable, is also driven on its own output. Interrupt sequencing itself lives elsewhere.

The dedicated set and clear forms for each named flag map onto the indexed forms. The decoder supplies the index of that flag.

Top module: `status_flag_reg`

## Requirements
- R1: While `rstN` is low, all eight flags read 0 at `statusQ`, and `intEnable` is 0.
- R2: Operation code 1 (set) makes status bit `bitIdx` read 1 after the next rising clock edge. Bit order from 7 to 0 is I, T, H, S, V, N, Z, C. No other bit changes unless the ALU mask selects it.
- R3: Operation code 2 (clear) makes status bit `bitIdx` read 0 after the next rising edge. No other bit changes unless the ALU mask selects it.
- R4: Operation code 3 (bit store) copies `srcByte[bitIdx]` into T (bit 6) at the next rising edge. It touches no other flag.
- R5: While operation code 4 (bit load) is applied, `dstByte` equals `srcByte` with bit `bitIdx` replaced by the current T. The status byte does not change because of it.
- R6: For every operation code other than 4, `dstByte` equals `srcByte`.
- R7: With no explicit flag write in the cycle, each status bit whose `aluMask` bit is 1 takes the matching `aluFlags` bit at the next edge. Bits whose mask bit is 0 keep their value.
- R8: When an explicit set, clear or bit store targets a bit that the ALU mask also selects, the explicit value is stored. The other masked bits still take the ALU values.
- R9: Operation codes 0, 5, 6 and 7 perform no explicit operation. The register changes only through the ALU mask.
- R10: `intEnable` always equals status bit 7 (I). Setting I enables interrupts and clearing I disables them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 3 | 0 none, 1 set flag, 2 clear flag, 3 bit store, 4 bit load, 5-7 none |
| bitIdx | input | 3 | Flag index for set/clear; source or destination bit for store/load |
| srcByte | input | 8 | General register value used by store and load |
| aluFlags | input | 8 | Flag values produced by the ALU |
| aluMask | input | 8 | One bit per flag; 1 lets the ALU value through |
| statusQ | output | 8 | Current status byte |
| dstByte | output | 8 | srcByte with T inserted for a bit load, otherwise srcByte unchanged |
| intEnable | output | 1 | Global interrupt enable (status bit 7) |

## Verification
A wrong flag is stored state, so it shows at `statusQ` on the first sampling point after the faulty edge. Since T also feeds the bit-load path, a corrupted T further reaches `dstByte` during the next load. A fault in the bit-load path is combinational and shows on `dstByte` in the same cycle the operation is applied. Random mixes of operations, indices and ALU masks run against a bench model. The same-bit collisions between an explicit write and the ALU mask are driven on purpose, because the priority error only surfaces there.

// File: rtl/status_flag_pkg.sv
package status_flag_pkg;
  localparam int FLAG_W = 8;
  localparam int IDX_W  = $clog2(FLAG_W);
  localparam int OP_W   = 3;
  localparam int T_POS  = 6;
  localparam int I_POS  = 7;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 3'd0,
    OP_SET   = 3'd1,
    OP_CLR   = 3'd2,
    OP_STORE = 3'd3,
    OP_LOAD  = 3'd4
  } flagOp_e;

  typedef struct packed {
    logic             setEn;
    logic             clrEn;
    logic             storeEn;
    logic             loadEn;
    logic [IDX_W-1:0] idx;
  } ctrlStrobe_t;
endpackage

// File: rtl/status_flag_ctrl.sv
module status_flag_ctrl
  import status_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OP_W-1:0]  opCode,
  input  logic [IDX_W-1:0] bitIdx,
  output ctrlStrobe_t      strb
);
  always_comb begin
    strb         = '0;
    strb.idx     = bitIdx;
    case (opCode)
      OP_SET:   strb.setEn   = 1'b1;
      OP_CLR:   strb.clrEn   = 1'b1;
      OP_STORE: strb.storeEn = 1'b1;
      OP_LOAD:  strb.loadEn  = 1'b1;
      default:  ;
    endcase
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setEn, strb.clrEn, strb.storeEn, strb.loadEn}));

  // R9
  unused_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode > 3'd4 || opCode == 3'd0) |->
      !(strb.setEn || strb.clrEn || strb.storeEn || strb.loadEn));
endmodule

// File: rtl/status_flag_dp.sv
module status_flag_dp
  import status_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [FLAG_W-1:0] srcByte,
  input  logic [FLAG_W-1:0] aluFlags,
  input  logic [FLAG_W-1:0] aluMask,
  output logic [FLAG_W-1:0] statusQ,
  output logic [FLAG_W-1:0] dstByte
);
  logic [FLAG_W-1:0] flagsQ;
  logic [FLAG_W-1:0] flagsD;
  logic [IDX_W-1:0]  tgtIdx;
  logic              writeEn;
  logic              writeVal;
  logic              srcBit;
  logic              tBit;

  assign tBit     = flagsQ[T_POS];
  assign srcBit   = srcByte[strb.idx];
  assign writeEn  = strb.setEn | strb.clrEn | strb.storeEn;
  assign tgtIdx   = strb.storeEn ? IDX_W'(T_POS) : strb.idx;
  assign writeVal = strb.setEn ? 1'b1 : (strb.clrEn ? 1'b0 : srcBit);

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    logic hit;
    assign hit = writeEn && (tgtIdx == IDX_W'(i));
    always_comb begin
      if (hit)             flagsD[i] = writeVal;
      else if (aluMask[i]) flagsD[i] = aluFlags[i];
      else                 flagsD[i] = flagsQ[i];
    end
    assign dstByte[i] = (strb.loadEn && strb.idx == IDX_W'(i)) ? tBit : srcByte[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= flagsD;
  end

  assign statusQ = flagsQ;

  // R2
  set_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEn |=> flagsQ[$past(strb.idx)] == 1'b1);

  // R3
  clr_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEn |=> flagsQ[$past(strb.idx)] == 1'b0);

  // R4
  store_t_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeEn |=> flagsQ[T_POS] == $past(srcByte[strb.idx]));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setEn && !strb.clrEn && !strb.storeEn && aluMask == '0) |=> $stable(flagsQ));

  // R7
  alu_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setEn && !strb.clrEn && !strb.storeEn) |=>
      ((flagsQ & $past(aluMask)) == ($past(aluFlags) & $past(aluMask))));
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import status_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opCode,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [FLAG_W-1:0] srcByte,
  input  logic [FLAG_W-1:0] aluFlags,
  input  logic [FLAG_W-1:0] aluMask,
  output logic [FLAG_W-1:0] statusQ,
  output logic [FLAG_W-1:0] dstByte,
  output logic              intEnable
);
  ctrlStrobe_t strb;

  status_flag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opCode(opCode), .bitIdx(bitIdx), .strb(strb)
  );

  status_flag_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcByte(srcByte),
    .aluFlags(aluFlags), .aluMask(aluMask), .statusQ(statusQ), .dstByte(dstByte)
  );

  assign intEnable = statusQ[I_POS];

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |-> statusQ == '0);

  // R10
  int_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    intEnable == statusQ[I_POS]);
endmodule

// File: tb/sim_status_flag_reg.sv
module sim_status_flag_reg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] opCode = '0;
  logic [2:0] bitIdx = '0;
  logic [7:0] srcByte = '0, aluFlags = '0, aluMask = '0;
  logic [7:0] statusQ, dstByte;
  logic       intEnable;

  int checks = 0;
  int fails  = 0;
  logic [7:0] expStatus = '0;
  bit done = 0;

  always #4 clk = ~clk;

  status_flag_reg u0 (
    .clk(clk), .rstN(rstN), .opCode(opCode), .bitIdx(bitIdx), .srcByte(srcByte),
    .aluFlags(aluFlags), .aluMask(aluMask), .statusQ(statusQ), .dstByte(dstByte),
    .intEnable(intEnable)
  );

  function automatic logic [7:0] modelNext(logic [7:0] cur, logic [2:0] op, logic [2:0] ix,
                                           logic [7:0] src, logic [7:0] fl, logic [7:0] mk);
    logic [7:0] n = (cur & ~mk) | (fl & mk);
    case (op)
      3'd1: n[ix] = 1'b1;
      3'd2: n[ix] = 1'b0;
      3'd3: n[6]  = src[ix];
      default: ;
    endcase
    return n;
  endfunction

  function automatic logic [7:0] modelDst(logic [7:0] cur, logic [2:0] op, logic [2:0] ix,
                                          logic [7:0] src);
    logic [7:0] d = src;
    if (op == 3'd4) d[ix] = cur[6];
    return d;
  endfunction

  function automatic string tagOf(logic [2:0] op, logic [7:0] mk);
    case (op)
      3'd1: return (mk != 0) ? "R2/R8" : "R2";
      3'd2: return (mk != 0) ? "R3/R8" : "R3";
      3'd3: return (mk != 0) ? "R4/R8" : "R4";
      3'd4: return "R5";
      default: return (mk != 0) ? "R7" : "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; leaves the bench at the following falling edge.
  task automatic step(logic [2:0] op, logic [2:0] ix, logic [7:0] src,
                      logic [7:0] fl, logic [7:0] mk);
    opCode = op; bitIdx = ix; srcByte = src; aluFlags = fl; aluMask = mk;
    #1;
    check((op == 3'd4) ? "R5" : "R6", dstByte, modelDst(expStatus, op, ix, src));
    @(posedge clk);
    expStatus = modelNext(expStatus, op, ix, src, fl, mk);
    @(negedge clk);
    check(tagOf(op, mk), statusQ, expStatus);
    check("R10", {7'd0, intEnable}, {7'd0, expStatus[7]});
  endtask

  initial begin
    void'($urandom(32'd20240607));
    aluFlags = 8'hFF; aluMask = 8'hFF; opCode = 3'd1;
    repeat (3) @(negedge clk);
    check("R1", statusQ, 8'h00);
    check("R1", {7'd0, intEnable}, 8'h00);
    rstN = 1'b1;
    opCode = '0; aluMask = '0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) step(3'd1, 3'(i), 8'h00, 8'h00, 8'h00);   // R2 every index
    for (int i = 0; i < 8; i++) step(3'd2, 3'(i), 8'h00, 8'h00, 8'h00);   // R3 every index
    step(3'd1, 3'd7, 8'h00, 8'h00, 8'h00);                                // R10 I set
    step(3'd2, 3'd7, 8'h00, 8'h00, 8'h00);                                // R10 I clear
    step(3'd3, 3'd5, 8'h20, 8'h00, 8'h00);                                // R4 store 1
    step(3'd4, 3'd0, 8'h00, 8'h00, 8'h00);                                // R5 insert T=1
    step(3'd3, 3'd2, 8'hFB, 8'h00, 8'h00);                                // R4 store 0
    step(3'd4, 3'd7, 8'hFF, 8'h00, 8'h00);                                // R5 insert T=0
    step(3'd0, 3'd0, 8'hA5, 8'h5A, 8'hFF);                                // R7 full mask
    step(3'd2, 3'd1, 8'h00, 8'hFF, 8'hFF);                                // R8 clear vs ALU
    step(3'd1, 3'd0, 8'h00, 8'h00, 8'hFF);                                // R8 set vs ALU
    step(3'd3, 3'd0, 8'h00, 8'h40, 8'h40);                                // R8 store vs ALU on T
    for (int c = 5; c < 8; c++) step(3'(c), 3'd3, 8'hFF, 8'h00, 8'h00);   // R9 unused codes
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op = 3'($urandom % 8);
      logic [7:0] mk = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      step(op, 3'($urandom), 8'($urandom), 8'($urandom), mk);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule